// File: doc/BRIEF.md
# Cache Residency Length Monitor

This profiler sits beside a direct-mapped cache model and measures how long each block stays in its line. The length is counted in references served, not in cycles. Each line has its own saturating reference counter, which is cleared when a block is filled into the line. The counter steps once for every load or store that hits the resident block. When the cache evicts the block, the monitor sends the final count out on a valid/data stream.

Every reported length also updates two histograms over power-of-two length bins. The count histogram records how many residencies fell into the bin. The mass histogram records how many references those residencies served. Together they show whether a few long residencies carry most of the traffic while most residencies stay short.

At the end of a run, a flush request walks the lines in ascending index order, one line per cycle. It reports every block still resident and signals completion. The line index supplied with each strobe is the block address modulo the number of lines, as in any direct-mapped arrangement.

Top module: `residency_monitor`

## Requirements
- R1: After reset, resValid and flushDone are low, every histogram bin reads zero, and no line holds a block, so an eviction reports nothing.
- R2: A fill makes the line resident with its counter at zero; evicting it with no access in between reports length 0. A fill on a line that is already resident restarts its counter and reports nothing.
- R3: Each access to a resident line adds one to that line's counter. An eviction of a resident line drives resValid high for exactly one cycle, in the cycle after the strobe is sampled, with resLen equal to the count.
- R4: A line counter saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R5: An access or eviction aimed at a line that holds no block has no effect: no report, and no change to any counter.
- R6: An eviction, a fill and an access to the same line in one cycle report the old count. The new residency then starts from zero, and that same-cycle access counts toward it, leaving a count of 1.
- R7: An access and an eviction to the same line in one cycle, without a fill, report the count before that access, and the line is no longer resident afterwards.
- R8: Each report adds one to count bin k. For a length L, k is 0 when L=0; otherwise k is the position of L's highest set bit plus one, capped at NUM_BINS-1. With the default of 6 bins: 1→1, 2..3→2, 4..7→3, 8..15→4, 16 and above→5. histCount shows the bin chosen by histSel and reads zero for a histSel of NUM_BINS or more.
- R9: Each report adds its length L to mass bin k (same k as in R8), which histMass shows for histSel. Count and mass bins saturate instead of wrapping.
- R10: A flushReq sampled while no walk is in progress starts a walk. On the i-th following edge (i = 1..LINES), line i-1 is visited: if it is resident, it is reported and released. flushDone is high for exactly one cycle, together with the visit of the last line.
- R11: Access, fill and evict strobes are ignored in the cycle flushReq is sampled and throughout a walk, and a flushReq during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A reference was served by line accLine |
| accLine | input | LINE_W | Line of the reference |
| fillValid | input | 1 | A new block is placed in line fillLine |
| fillLine | input | LINE_W | Line being filled |
| evictValid | input | 1 | The block in line evictLine leaves the cache |
| evictLine | input | LINE_W | Line being evicted |
| flushReq | input | 1 | Start the end-of-run walk |
| histSel | input | BIN_W | Bin shown on the histogram outputs |
| resValid | output | 1 | A residency length is reported this cycle |
| resLen | output | CNT_W | Reported residency length |
| flushDone | output | 1 | The walk has visited the last line |
| histCount | output | HCNT_W | Residency count of the selected bin |
| histMass | output | MASS_W | Reference mass of the selected bin |

## Verification
The hardest situations to reach are the same-cycle collisions on one line: eviction with fill and access, and access with eviction but no fill. In these cases the reported length must be the old count, and the leftover state decides every later report. Directed steps build each collision on a line with a known count and then evict again to expose what was left behind. The constrained random phase draws from only eight lines, with high strobe rates, so collisions and near-saturated counts also occur there. Its final flush is fed random strobes on every walk cycle, to show they leave the walk's reports untouched.

// File: rtl/resmon_pkg.sv
package resmon_pkg;

  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic report;  // release line repLine and report it if resident
    logic fill;    // start a new residency on fillLine
    logic access;  // count a reference on accLine
  } strobe_t;

  // Length-to-bin mapping: highest set bit position + 1, capped at the top bin.
  function automatic int unsigned bin_of(input logic [31:0] len, input int unsigned numBins);
    int unsigned b;
    b = 0;
    for (int i = 0; i < 32; i++) begin
      if (len[i]) b = i + 1;
    end
    if (b > numBins - 1) b = numBins - 1;
    return b;
  endfunction

endpackage

// File: rtl/resmon_ctrl.sv
module resmon_ctrl
  import resmon_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              fillValid,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  input  logic              flushReq,
  output strobe_t           stb,
  output logic [LINE_W-1:0] repLine,
  output logic              walking,
  output logic              flushDone
);

  logic [LINE_W-1:0] walkIdx;
  logic              blockIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walking   <= 1'b0;
      walkIdx   <= '0;
      flushDone <= 1'b0;
    end else begin
      flushDone <= 1'b0;
      if (walking) begin
        if (walkIdx == LINE_W'(LINES - 1)) begin
          walking   <= 1'b0;
          walkIdx   <= '0;
          flushDone <= 1'b1;
        end else begin
          walkIdx <= walkIdx + 1'b1;
        end
      end else if (flushReq) begin
        walking <= 1'b1;
        walkIdx <= '0;
      end
    end
  end

  always_comb begin
    blockIn    = walking | flushReq;
    stb.report = walking | (evictValid & ~blockIn);
    stb.fill   = fillValid & ~blockIn;
    stb.access = accValid & ~blockIn;
    repLine    = walking ? walkIdx : evictLine;
  end

endmodule

// File: rtl/resmon_datapath.sv
module resmon_datapath
  import resmon_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int LINE_W   = 3,
  parameter int CNT_W    = 8,
  parameter int NUM_BINS = 6,
  parameter int BIN_W    = 3,
  parameter int HCNT_W   = 16,
  parameter int MASS_W   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [LINE_W-1:0] repLine,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [LINE_W-1:0] accLine,
  input  logic [BIN_W-1:0]  histSel,
  output logic              resValid,
  output logic [CNT_W-1:0]  resLen,
  output logic [HCNT_W-1:0] histCount,
  output logic [MASS_W-1:0] histMass
);

  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [HCNT_W-1:0] HCNT_MAX = '1;
  localparam logic [MASS_W-1:0] MASS_MAX = '1;

  logic [CNT_W-1:0]  lineCnt   [LINES];
  logic              lineValid [LINES];
  logic [HCNT_W-1:0] binCount  [NUM_BINS];
  logic [MASS_W-1:0] binMass   [NUM_BINS];

  logic              repHit;
  logic [CNT_W-1:0]  repVal;
  logic [BIN_W-1:0]  repBin;

  always_comb begin
    repHit = 1'b0;
    repVal = '0;
    for (int i = 0; i < LINES; i++) begin
      if (repLine == LINE_W'(i)) begin
        repHit = stb.report & lineValid[i];
        repVal = lineCnt[i];
      end
    end
    repBin = BIN_W'(bin_of(32'(repVal), NUM_BINS));
  end

  // Per-line residency state.
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic             killHere, fillHere, accHere, nextValid;
    logic [CNT_W-1:0] baseCnt, nextCnt;

    always_comb begin
      killHere  = stb.report & (repLine == LINE_W'(g));
      fillHere  = stb.fill & (fillLine == LINE_W'(g));
      accHere   = stb.access & (accLine == LINE_W'(g));
      nextValid = (lineValid[g] & ~killHere) | fillHere;
      baseCnt   = fillHere ? '0 : lineCnt[g];
      nextCnt   = (accHere && nextValid && baseCnt != CNT_MAX) ? baseCnt + 1'b1 : baseCnt;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid[g] <= 1'b0;
        lineCnt[g]   <= '0;
      end else begin
        lineValid[g] <= nextValid;
        lineCnt[g]   <= nextCnt;
      end
    end
  end

  // Histogram bins.
  for (genvar b = 0; b < NUM_BINS; b++) begin : gBin
    logic [MASS_W:0] massSum;
    assign massSum = {1'b0, binMass[b]} + (MASS_W + 1)'(repVal);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        binCount[b] <= '0;
        binMass[b]  <= '0;
      end else if (repHit && repBin == BIN_W'(b)) begin
        if (binCount[b] != HCNT_MAX) binCount[b] <= binCount[b] + 1'b1;
        binMass[b] <= massSum[MASS_W] ? MASS_MAX : massSum[MASS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resLen   <= '0;
    end else begin
      resValid <= repHit;
      resLen   <= repVal;
    end
  end

  always_comb begin
    histCount = '0;
    histMass  = '0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (histSel == BIN_W'(b)) begin
        histCount = binCount[b];
        histMass  = binMass[b];
      end
    end
  end

endmodule

// File: rtl/residency_monitor.sv
module residency_monitor
  import resmon_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int CNT_W    = 8,
  parameter int NUM_BINS = 6,
  parameter int HCNT_W   = 16,
  parameter int MASS_W   = 20,
  localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS + 1) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [LINE_W-1:0] accLine,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  input  logic              flushReq,
  input  logic [BIN_W-1:0]  histSel,
  output logic              resValid,
  output logic [CNT_W-1:0]  resLen,
  output logic              flushDone,
  output logic [HCNT_W-1:0] histCount,
  output logic [MASS_W-1:0] histMass
);

  strobe_t           stb;
  logic [LINE_W-1:0] repLine;
  logic              walking;

  resmon_ctrl #(.LINES(LINES), .LINE_W(LINE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .fillValid(fillValid),
    .evictValid(evictValid), .evictLine(evictLine),
    .flushReq(flushReq),
    .stb(stb), .repLine(repLine), .walking(walking), .flushDone(flushDone)
  );

  resmon_datapath #(
    .LINES(LINES), .LINE_W(LINE_W), .CNT_W(CNT_W), .NUM_BINS(NUM_BINS),
    .BIN_W(BIN_W), .HCNT_W(HCNT_W), .MASS_W(MASS_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .repLine(repLine),
    .fillLine(fillLine), .accLine(accLine), .histSel(histSel),
    .resValid(resValid), .resLen(resLen),
    .histCount(histCount), .histMass(histMass)
  );

endmodule

// File: rtl/resmon_checker.sv
module resmon_checker #(
  parameter int BIN_W = 3,
  parameter int HC_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             flushReq,
  input logic             evictValid,
  input logic             walking,
  input logic             resValid,
  input logic             flushDone,
  input logic [BIN_W-1:0] histSel,
  input logic [HC_W-1:0]  histCount
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  // R10
  done_ends_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> !walking);

  // R11
  walk_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !walking) |=> walking);

  // R3
  report_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(evictValid || walking));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(histSel) && !resValid) |-> $stable(histCount));

endmodule

bind residency_monitor resmon_checker #(.BIN_W(BIN_W), .HC_W(HCNT_W)) uChk (
  .clk(clk), .rstN(rstN), .flushReq(flushReq), .evictValid(evictValid),
  .walking(walking), .resValid(resValid), .flushDone(flushDone),
  .histSel(histSel), .histCount(histCount)
);

// File: tb/residency_monitor_test.sv
`timescale 1ns/1ps
module residency_monitor_test;

  localparam int LINES = 8, CNT_W = 8, NB = 6, HC_W = 16, MS_W = 20;
  localparam int LW = 3, BW = 3;
  localparam int CMAX = 255;
  localparam longint HMAX = 65535, MMAX = 1048575;

  logic clk = 1'b0, rstN = 1'b0;
  logic accValid = 0, fillValid = 0, evictValid = 0, flushReq = 0;
  logic [LW-1:0] accLine = '0, fillLine = '0, evictLine = '0;
  logic [BW-1:0] histSel = '0;
  logic resValid, flushDone;
  logic [CNT_W-1:0] resLen;
  logic [HC_W-1:0] histCount;
  logic [MS_W-1:0] histMass;

  always #4 clk = ~clk;

  residency_monitor #(.LINES(LINES), .CNT_W(CNT_W), .NUM_BINS(NB),
                      .HCNT_W(HC_W), .MASS_W(MS_W)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accLine(accLine),
    .fillValid(fillValid), .fillLine(fillLine), .evictValid(evictValid),
    .evictLine(evictLine), .flushReq(flushReq), .histSel(histSel),
    .resValid(resValid), .resLen(resLen), .flushDone(flushDone),
    .histCount(histCount), .histMass(histMass)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  bit mValid [LINES];
  int mCnt [LINES];
  longint mHc [NB];
  longint mHm [NB];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expBin(input int len);
    int b = 0;
    for (int i = 0; i < 31; i++) if ((len >> i) & 1) b = i + 1;
    return (b > NB - 1) ? NB - 1 : b;
  endfunction

  task automatic modelReport(input int len);
    int b = expBin(len);
    mHc[b] = (mHc[b] + 1 > HMAX) ? HMAX : mHc[b] + 1;
    mHm[b] = (mHm[b] + len > MMAX) ? MMAX : mHm[b] + len;
  endtask

  // One normal cycle; report expectation follows R3/R5/R6/R7.
  task automatic step(input bit a, input int al, input bit f, input int fl,
                      input bit e, input int el, input string tag);
    bit expRep;
    int expLen;
    @(negedge clk);
    accValid = a; accLine = LW'(al);
    fillValid = f; fillLine = LW'(fl);
    evictValid = e; evictLine = LW'(el);
    flushReq = 0;
    expRep = e && mValid[el];
    expLen = mCnt[el];
    if (e) mValid[el] = 0;
    if (f) begin mValid[fl] = 1; mCnt[fl] = 0; end
    if (a && mValid[al] && mCnt[al] < CMAX) mCnt[al]++;
    if (expRep) modelReport(expLen);
    @(posedge clk); #1;
    check(resValid == expRep, {tag, " valid"}, resValid, expRep);
    if (expRep) check(resLen == CNT_W'(expLen), {tag, " len"}, resLen, expLen);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic flushWalk();
    @(negedge clk);
    flushReq = 1;
    accValid = 1; accLine = LW'($urandom % LINES);
    fillValid = 1; fillLine = LW'($urandom % LINES);
    evictValid = 1; evictLine = LW'($urandom % LINES);
    @(posedge clk); #1;
    // R11 strobes sampled with flushReq are ignored
    check(resValid == 0, "R11 flush start", resValid, 0);
    for (int i = 0; i < LINES; i++) begin
      @(negedge clk);
      flushReq = 1'($urandom % 2);
      accValid = 1'($urandom % 2); accLine = LW'($urandom % LINES);
      fillValid = 1'($urandom % 2); fillLine = LW'($urandom % LINES);
      evictValid = 1'($urandom % 2); evictLine = LW'($urandom % LINES);
      @(posedge clk); #1;
      check(resValid == mValid[i], "R10 walk valid", resValid, mValid[i]);
      if (mValid[i]) begin
        check(resLen == CNT_W'(mCnt[i]), "R10 walk len", resLen, mCnt[i]);
        modelReport(mCnt[i]);
      end
      mValid[i] = 0;
      check(flushDone == (i == LINES - 1), "R10 done timing", flushDone, (i == LINES - 1));
    end
    @(negedge clk);
    flushReq = 0; accValid = 0; fillValid = 0; evictValid = 0;
    @(posedge clk); #1;
    check(flushDone == 0, "R10 done pulse", flushDone, 0);
    check(resValid == 0, "R11 walk over", resValid, 0);
  endtask

  task automatic histCheck(input string tag);
    for (int b = 0; b < 8; b++) begin
      longint ec, em;
      @(negedge clk);
      histSel = BW'(b);
      #1;
      ec = (b < NB) ? mHc[b] : 0;
      em = (b < NB) ? mHm[b] : 0;
      check(histCount == HC_W'(ec), {tag, " R8 count"}, histCount, ec);
      check(histMass == MS_W'(em), {tag, " R9 mass"}, histMass, em);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin mValid[i] = 0; mCnt[i] = 0; end
    for (int b = 0; b < NB; b++) begin mHc[b] = 0; mHm[b] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(resValid == 0, "R1 resValid", resValid, 0);
    check(flushDone == 0, "R1 flushDone", flushDone, 0);
    @(negedge clk); rstN = 1;
    histCheck("R1");
    step(0, 0, 0, 0, 1, 3, "R1 evict after reset");

    // R2 empty residency
    step(0, 0, 1, 2, 0, 0, "R2 fill");
    step(0, 0, 0, 0, 1, 2, "R2 evict zero");
    // R2 refill of a resident line restarts silently
    step(0, 0, 1, 2, 0, 0, "R2 fill again");
    step(1, 2, 0, 0, 0, 0, "R2 access");
    step(0, 0, 1, 2, 0, 0, "R2 refill no report");
    step(0, 0, 0, 0, 1, 2, "R2 refill evict zero");

    // R3 counting and one-cycle report
    step(0, 0, 1, 1, 0, 0, "R3 fill");
    for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 0, "R3 access");
    step(0, 0, 0, 0, 1, 1, "R3 evict five");
    idle("R3 single-cycle report");

    // R5 stray access/evict on empty line
    step(1, 4, 0, 0, 0, 0, "R5 access empty");
    step(0, 0, 0, 0, 1, 4, "R5 evict empty");
    step(0, 0, 1, 4, 0, 0, "R5 fill");
    step(0, 0, 0, 0, 1, 4, "R5 evict zero");

    // R6 evict+fill+access collision
    step(0, 0, 1, 0, 0, 0, "R6 fill");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, "R6 access");
    step(1, 0, 1, 0, 1, 0, "R6 collision old count");
    step(0, 0, 0, 0, 1, 0, "R6 new residency one");

    // R7 access+evict without fill
    step(0, 0, 1, 6, 0, 0, "R7 fill");
    step(1, 6, 0, 0, 0, 0, "R7 access");
    step(1, 6, 0, 0, 0, 0, "R7 access");
    step(1, 6, 0, 0, 1, 6, "R7 access with evict");
    step(0, 0, 0, 0, 1, 6, "R7 line released");

    // R4 saturation
    step(0, 0, 1, 7, 0, 0, "R4 fill");
    for (int k = 0; k < 300; k++) step(1, 7, 0, 0, 0, 0, "R4 access");
    step(0, 0, 0, 0, 1, 7, "R4 evict saturated");

    histCheck("directed");

    // Flush with a few lines resident
    step(0, 0, 1, 3, 0, 0, "R10 fill");
    step(1, 3, 1, 5, 0, 0, "R10 fill");
    flushWalk();
    step(0, 0, 0, 0, 1, 3, "R10 released by walk");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit a, f, e;
      a = ($urandom % 100) < 60;
      f = ($urandom % 100) < 25;
      e = ($urandom % 100) < 20;
      step(a, $urandom % LINES, f, $urandom % LINES, e, $urandom % LINES, "R3 random");
    end
    histCheck("random");
    flushWalk();
    histCheck("after flush");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule